// File: doc/BRIEF.md
# Clock Path Selector and Divider

This block turns a choice of clock sources into the two enable streams that pace a small controller: a system enable that every peripheral uses, and a slower CPU enable derived from it. Each source enters as a one-cycle tick in a single fast clock domain. The three sources are a crystal reference, an already multiplied PLL output together with its lock flag, and a slow internal auxiliary oscillator. The outputs are enable pulses in that same domain, never gated clocks.

There are three paths. The reference can be halved before use. Its slow bypass divides by sixteen and serves whenever the multiplier is off or not yet locked. The PLL path has a post-divider of one to seven. The auxiliary path passes every tick, or one in sixteen during a low-power wait. The block also reports the multiplication factor picked by a 2-bit field, so a PLL model can use it, and it gives back the undivided PLL tick as a separate high-speed enable. A source or divider change is taken up only when the current output period ends, so no enable period is cut short or doubled.

Top module: `ckSelDiv`

## Requirements
- R1: While `rstN` is low, `sysTick` and `cpuTick` are low. Reset selects the reference bypass path at divide-by-16 with no halving, and sets the CPU factor to 1. With `refTick` high every cycle, the first `sysTick` comes 16 cycles after reset is released.
- R2: With `auxSel`=0 and `pllOn`=0, `sysTick` pulses once for every 16 ticks of the (possibly halved) reference.
- R3: With `halfEn`=1 on the reference path, only every second `refTick` counts, so `sysTick` pulses once per 32 reference ticks.
- R4: With `pllOn`=1, the lock flag high and `auxSel`=0, `sysTick` pulses once per N `pllTick`s. N is the value of `postDiv` (1 to 7), and a value of 0 gives N=1.
- R5: `mulFactor` reports the multiplication factor from `mulSel`: 0 gives 6, 1 gives 8, 2 gives 10 and 3 gives 14.
- R6: `auxSel`=1 selects the auxiliary source ahead of the PLL and the reference. `sysTick` then follows every `auxTick`, or one in 16 `auxTick`s when `lpWait`=1.
- R7: `cpuTick` pulses on every (`prescSel`+1)-th `sysTick`, in the same cycle as that `sysTick`. This gives factors from 1 to 8.
- R8: `pllFastTick` repeats `pllTick` one clock later, undivided.
- R9: A change of source or divider takes effect only after the current `sysTick` period has ended. A change of `prescSel` takes effect only after the current `cpuTick` period has ended.
- R10: While `pllLock` is low, setting `pllOn`=1 leaves the system enable on the divide-by-16 reference path.
- R11: The dividers count source ticks, not clock cycles. With `refTick` once every 3 cycles on the bypass path, `sysTick` pulses every 48 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock for the whole block |
| rstN | input | 1 | Synchronous active-low reset |
| refTick | input | 1 | One-cycle tick of the crystal reference |
| pllTick | input | 1 | One-cycle tick of the multiplied PLL clock |
| auxTick | input | 1 | One-cycle tick of the slow internal oscillator |
| pllLock | input | 1 | PLL lock flag |
| pllOn | input | 1 | Request for the multiplier path |
| auxSel | input | 1 | Selects the auxiliary source |
| lpWait | input | 1 | Low-power wait in progress (auxiliary /16) |
| halfEn | input | 1 | Halves the reference before use |
| postDiv | input | 3 | PLL post-divider, 0 treated as 1 |
| mulSel | input | 2 | Multiplication factor code |
| prescSel | input | 3 | CPU prescaler, factor = value + 1 |
| sysTick | output | 1 | System (peripheral) enable pulse |
| cpuTick | output | 1 | CPU enable pulse |
| pllFastTick | output | 1 | Undivided PLL tick, one cycle late |
| mulFactor | output | 4 | Decoded multiplication factor |

## Verification
Some properties are checked on every cycle. Reset keeps both enables low. A CPU enable always falls on a system enable. The fast PLL output repeats its input one cycle later. The PLL path is never committed unless lock was high. A new period longer than one tick never produces two system pulses in a row. The scenarios alone can show the actual division ratios of each path: the halving, the bypass, the post-divider and its zero case, the auxiliary low-power divide and the prescaler factors. They also show that a change made in the middle of a period leaves that period at its old length.

// File: rtl/ckPkg.sv
package ckPkg;
  localparam int POST_W   = 3;
  localparam int PRESC_W  = 3;
  localparam int MUL_W    = 2;
  localparam int FACT_W   = 4;
  localparam int SLOW_DIV = 16;
  localparam int CNT_W    = $clog2(SLOW_DIV);

  typedef enum logic [1:0] {
    SRC_REF = 2'd0,
    SRC_PLL = 2'd1,
    SRC_AUX = 2'd2
  } srcSelE;

  // committed configuration, control -> datapath
  typedef struct packed {
    srcSelE              src;
    logic [CNT_W-1:0]    divM1;
    logic                halfOn;
    logic [PRESC_W-1:0]  presc;
  } ctlBusT;

  // period-end strobes, datapath -> control
  typedef struct packed {
    logic sysEnd;
    logic cpuEnd;
  } endBusT;

  function automatic logic [FACT_W-1:0] mulDecode(input logic [MUL_W-1:0] code);
    case (code)
      2'd0:    mulDecode = FACT_W'(6);
      2'd1:    mulDecode = FACT_W'(8);
      2'd2:    mulDecode = FACT_W'(10);
      default: mulDecode = FACT_W'(14);
    endcase
  endfunction
endpackage

// File: rtl/ckCtrl.sv
module ckCtrl
  import ckPkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               pllLock,
  input  logic               pllOn,
  input  logic               auxSel,
  input  logic               lpWait,
  input  logic               halfEn,
  input  logic [POST_W-1:0]  postDiv,
  input  logic [MUL_W-1:0]   mulSel,
  input  logic [PRESC_W-1:0] prescSel,
  input  endBusT             endBus,
  output ctlBusT             ctlBus,
  output logic [FACT_W-1:0]  mulFactor
);
  localparam logic [CNT_W-1:0] SLOW_M1 = CNT_W'(SLOW_DIV - 1);

  srcSelE           nextSrc;
  logic [CNT_W-1:0] nextDivM1;

  always_comb begin
    if (auxSel)               nextSrc = SRC_AUX;
    else if (pllOn && pllLock) nextSrc = SRC_PLL;
    else                      nextSrc = SRC_REF;
  end

  always_comb begin
    case (nextSrc)
      SRC_AUX: nextDivM1 = lpWait ? SLOW_M1 : '0;
      SRC_PLL: nextDivM1 = (postDiv == '0) ? '0 : CNT_W'(postDiv - POST_W'(1));
      default: nextDivM1 = SLOW_M1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctlBus.src    <= SRC_REF;
      ctlBus.divM1  <= SLOW_M1;
      ctlBus.halfOn <= 1'b0;
      ctlBus.presc  <= '0;
    end else begin
      if (endBus.sysEnd) begin
        ctlBus.src    <= nextSrc;
        ctlBus.divM1  <= nextDivM1;
        ctlBus.halfOn <= halfEn;
      end
      if (endBus.cpuEnd) begin
        ctlBus.presc <= prescSel;
      end
    end
  end

  assign mulFactor = mulDecode(mulSel);
endmodule

// File: rtl/ckData.sv
module ckData
  import ckPkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   refTick,
  input  logic   pllTick,
  input  logic   auxTick,
  input  ctlBusT ctlBus,
  output endBusT endBus,
  output logic   sysTick,
  output logic   cpuTick,
  output logic   pllFastTick
);
  logic               halfPhase;
  logic               clk2Tick;
  logic               srcTick;
  logic [CNT_W-1:0]   divCnt;
  logic [PRESC_W-1:0] preCnt;

  assign clk2Tick = refTick && (!ctlBus.halfOn || halfPhase);

  always_comb begin
    case (ctlBus.src)
      SRC_PLL: srcTick = pllTick;
      SRC_AUX: srcTick = auxTick;
      default: srcTick = clk2Tick;
    endcase
  end

  assign endBus.sysEnd = srcTick && (divCnt == ctlBus.divM1);
  assign endBus.cpuEnd = endBus.sysEnd && (preCnt == ctlBus.presc);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      halfPhase <= 1'b0;
      divCnt    <= '0;
    end else if (endBus.sysEnd) begin
      halfPhase <= 1'b0;
      divCnt    <= '0;
    end else begin
      if (refTick && ctlBus.halfOn) halfPhase <= !halfPhase;
      if (srcTick) divCnt <= divCnt + CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)               preCnt <= '0;
    else if (endBus.cpuEnd)  preCnt <= '0;
    else if (endBus.sysEnd)  preCnt <= preCnt + PRESC_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sysTick     <= 1'b0;
      cpuTick     <= 1'b0;
      pllFastTick <= 1'b0;
    end else begin
      sysTick     <= endBus.sysEnd;
      cpuTick     <= endBus.cpuEnd;
      pllFastTick <= pllTick;
    end
  end
endmodule

// File: rtl/ckSelDiv.sv
module ckSelDiv
  import ckPkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               refTick,
  input  logic               pllTick,
  input  logic               auxTick,
  input  logic               pllLock,
  input  logic               pllOn,
  input  logic               auxSel,
  input  logic               lpWait,
  input  logic               halfEn,
  input  logic [POST_W-1:0]  postDiv,
  input  logic [MUL_W-1:0]   mulSel,
  input  logic [PRESC_W-1:0] prescSel,
  output logic               sysTick,
  output logic               cpuTick,
  output logic               pllFastTick,
  output logic [FACT_W-1:0]  mulFactor
);
  ctlBusT ctlBus;
  endBusT endBus;

  ckCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .pllLock(pllLock), .pllOn(pllOn),
    .auxSel(auxSel), .lpWait(lpWait), .halfEn(halfEn), .postDiv(postDiv),
    .mulSel(mulSel), .prescSel(prescSel), .endBus(endBus),
    .ctlBus(ctlBus), .mulFactor(mulFactor)
  );

  ckData u_data (
    .clk(clk), .rstN(rstN), .refTick(refTick), .pllTick(pllTick),
    .auxTick(auxTick), .ctlBus(ctlBus), .endBus(endBus),
    .sysTick(sysTick), .cpuTick(cpuTick), .pllFastTick(pllFastTick)
  );
endmodule

// File: rtl/ckSelDiv_chk.sv
module ckSelDiv_chk
  import ckPkg::*;
(
  input logic   clk,
  input logic   rstN,
  input logic   pllTick,
  input logic   pllLock,
  input logic   sysTick,
  input logic   cpuTick,
  input logic   pllFastTick,
  input ctlBusT ctlBus
);
  // R1
  rst_quiet_chk: assert property (@(posedge clk)
    !rstN |=> (!sysTick && !cpuTick));

  // R7
  cpu_on_sys_chk: assert property (@(posedge clk) disable iff (!rstN)
    cpuTick |-> sysTick);

  // R8
  fast_echo_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> (pllFastTick == $past(pllTick)));

  // R10
  lock_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((ctlBus.src == SRC_PLL) && $past(ctlBus.src != SRC_PLL)) |-> $past(pllLock));

  // R9
  no_double_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sysTick && (ctlBus.divM1 != '0)) |=> !sysTick);
endmodule

bind ckSelDiv ckSelDiv_chk u_chk (
  .clk(clk), .rstN(rstN), .pllTick(pllTick), .pllLock(pllLock),
  .sysTick(sysTick), .cpuTick(cpuTick), .pllFastTick(pllFastTick),
  .ctlBus(ctlBus)
);

// File: tb/ckSelDiv_tb.sv
module ckSelDiv_tb;
  localparam time CYC = 20ns;
  localparam int  LIMIT = 3000;

  logic clk = 1'b0;
  logic rstN, refTick, pllTick, auxTick, pllLock, pllOn, auxSel, lpWait, halfEn;
  logic [2:0] postDiv;
  logic [1:0] mulSel;
  logic [2:0] prescSel;
  logic sysTick, cpuTick, pllFastTick;
  logic [3:0] mulFactor;

  int compared = 0;
  int mismatched = 0;
  int refEvery = 1, pllEvery = 1, auxEvery = 1;
  int genCnt = 0;

  always #(CYC/2) clk = !clk;

  ckSelDiv u_dut (
    .clk(clk), .rstN(rstN), .refTick(refTick), .pllTick(pllTick),
    .auxTick(auxTick), .pllLock(pllLock), .pllOn(pllOn), .auxSel(auxSel),
    .lpWait(lpWait), .halfEn(halfEn), .postDiv(postDiv), .mulSel(mulSel),
    .prescSel(prescSel), .sysTick(sysTick), .cpuTick(cpuTick),
    .pllFastTick(pllFastTick), .mulFactor(mulFactor)
  );

  // tick generators, updated shortly after each rising edge
  initial begin
    refTick = 1'b1; pllTick = 1'b1; auxTick = 1'b1;
    forever begin
      @(posedge clk);
      #2;
      genCnt++;
      refTick = (refEvery != 0) && (genCnt % refEvery == 0);
      pllTick = (pllEvery != 0) && (genCnt % pllEvery == 0);
      auxTick = (auxEvery != 0) && (genCnt % auxEvery == 0);
    end
  end

  task automatic check(input string req, input int got, input int exp);
    compared++;
    if (got != exp) begin
      mismatched++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic waitSys();
    for (int i = 0; i < LIMIT; i++) begin
      @(negedge clk);
      if (sysTick) return;
    end
  endtask

  task automatic gapSys(output int gap);
    waitSys();
    gap = -1;
    for (int n = 1; n <= LIMIT; n++) begin
      @(negedge clk);
      if (sysTick) begin gap = n; return; end
    end
  endtask

  task automatic gapCpu(output int gap);
    gap = -1;
    for (int i = 0; i < LIMIT; i++) begin
      @(negedge clk);
      if (cpuTick) break;
    end
    for (int n = 1; n <= LIMIT; n++) begin
      @(negedge clk);
      if (cpuTick) begin gap = n; return; end
    end
  endtask

  task automatic settle();
    waitSys();
    waitSys();
  endtask

  task automatic tReset();
    int n;
    rstN = 1'b0;
    repeat (4) @(negedge clk);
    check("R1 sysTick in reset", int'(sysTick), 0);
    check("R1 cpuTick in reset", int'(cpuTick), 0);
    rstN = 1'b1;
    n = -1;
    for (int k = 1; k <= LIMIT; k++) begin
      @(negedge clk);
      if (sysTick) begin n = k; break; end
    end
    check("R1 first sysTick after reset", n, 16);
  endtask

  task automatic tMul();
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      mulSel = 2'(c);
      #1;
      check("R5 mulFactor", int'(mulFactor), (c == 0) ? 6 : (c == 1) ? 8 : (c == 2) ? 10 : 14);
    end
  endtask

  task automatic tBypass();
    int g;
    gapSys(g);
    check("R2 bypass gap", g, 16);
    refEvery = 3;
    settle();
    gapSys(g);
    check("R11 bypass gap with sparse ref", g, 48);
    refEvery = 1;
    settle();
  endtask

  task automatic tHalve();
    int g;
    halfEn = 1'b1;
    settle();
    gapSys(g);
    check("R3 halved bypass gap", g, 32);
    halfEn = 1'b0;
    settle();
    gapSys(g);
    check("R3 halving off again", g, 16);
  endtask

  task automatic tLock();
    int g;
    pllLock = 1'b0; pllOn = 1'b1; postDiv = 3'd3;
    settle();
    gapSys(g);
    check("R10 unlocked stays on bypass", g, 16);
    pllLock = 1'b1;
    settle();
    gapSys(g);
    check("R10 locked takes PLL path", g, 3);
  endtask

  task automatic tPll();
    int g;
    int divs[4] = '{0, 1, 4, 7};
    int exps[4] = '{1, 1, 4, 7};
    pllOn = 1'b1; pllLock = 1'b1;
    for (int i = 0; i < 4; i++) begin
      postDiv = 3'(divs[i]);
      settle();
      gapSys(g);
      check("R4 PLL post-divider gap", g, exps[i]);
    end
    pllEvery = 2; postDiv = 3'd5;
    settle();
    gapSys(g);
    check("R4 post-divider on sparse PLL ticks", g, 10);
    pllEvery = 1;
  endtask

  task automatic tFast();
    logic prev;
    int bad = 0;
    pllEvery = 3;
    @(negedge clk);
    prev = pllTick;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (pllFastTick != prev) bad++;
      prev = pllTick;
    end
    check("R8 pllFastTick echoes pllTick", bad, 0);
    pllEvery = 1;
  endtask

  task automatic tBoundary();
    int n;
    int g;
    pllOn = 1'b0; postDiv = 3'd2;
    settle();
    waitSys();
    n = 0;
    repeat (5) begin @(negedge clk); n++; end
    pllOn = 1'b1; pllLock = 1'b1;
    for (int k = 0; k < LIMIT; k++) begin
      @(negedge clk);
      n++;
      if (sysTick) break;
    end
    check("R9 period in progress keeps old length", n, 16);
    gapSys(g);
    check("R9 new divider after boundary", g, 2);
  endtask

  task automatic tAux();
    int g;
    auxSel = 1'b1; lpWait = 1'b0; pllOn = 1'b1;
    settle();
    gapSys(g);
    check("R6 aux direct gap", g, 1);
    lpWait = 1'b1;
    settle();
    gapSys(g);
    check("R6 aux low-power gap", g, 16);
    auxEvery = 2;
    settle();
    gapSys(g);
    check("R6 aux low-power sparse gap", g, 32);
    auxEvery = 1; lpWait = 1'b0;
    settle();
  endtask

  task automatic tCpu();
    int g;
    int bad = 0;
    prescSel = 3'd3;
    settle();
    gapCpu(g); gapCpu(g);
    check("R7 cpu factor 4", g, 4);
    prescSel = 3'd7;
    gapCpu(g); gapCpu(g);
    check("R7 cpu factor 8", g, 8);
    prescSel = 3'd0;
    gapCpu(g); gapCpu(g);
    check("R7 cpu factor 1", g, 1);
    lpWait = 1'b1; prescSel = 3'd1;
    settle(); gapCpu(g); gapCpu(g);
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (cpuTick && !sysTick) bad++;
    end
    check("R7 cpuTick only with sysTick", bad, 0);
    gapCpu(g);
    check("R7 cpu factor 2 over aux /16", g, 32);
    lpWait = 1'b0;
  endtask

  initial begin
    #(CYC * 150000);
    mismatched++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    rstN = 1'b0; pllLock = 1'b0; pllOn = 1'b0; auxSel = 1'b0; lpWait = 1'b0;
    halfEn = 1'b0; postDiv = 3'd0; mulSel = 2'd0; prescSel = 3'd0;
    tReset();
    tMul();
    tBypass();
    tHalve();
    tLock();
    tPll();
    tFast();
    tBoundary();
    tAux();
    tCpu();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule